// File: doc/BRIEF.md
# Constructive Three-Valued Evaluator for a Cross-Coupled Gate Pair

This block decides, for one input vector, what a small cyclic Boolean network settles to when a wire may only take a value that can be proven from facts already known. The network is fixed: `X = I and not Y`, `Y = J and not X`. Inside, the network is four gates (two inverters and two two-input AND gates) plus the two captured inputs, six wires in total. Each wire is three-valued: unknown, proven 0, proven 1. A start strobe captures `in_i` and `in_j`, sets every gate wire to unknown and reloads each gate's count of inputs still unresolved. One propagation sweep then runs per clock, with every gate evaluated from the wire values of the previous sweep.

An AND gate resolves to 0 as soon as one input is proven 0, and resolves to 1 only when all inputs are proven 1. An inverter resolves only once its input is proven. When a sweep changes no wire, the fixpoint has been reached and `done` rises. If any wire is still unknown at that point, the vector has no constructive proof and `non_constructive` is raised next to `done`. Because a sweep reads only the values of the previous sweep, the result does not depend on the order in which gates are evaluated.

The controller has three states. IDLE is entered on reset. SWEEP is entered from any state when `start` is high. SWEEP moves to DONE after a sweep that changes no wire. DONE holds until the next `start`. No other transitions exist.

Top module: `tern_net_eval`

## Requirements
- R1: Wire values use the code 00 = unknown, 10 = proven 0, 01 = proven 1, and 11 never appears. After reset `x_val` and `y_val` are 00 and `done` and `non_constructive` are 0.
- R2: An AND gate output reads 10 in the sweep after any one of its inputs is proven 0, even while its other input is unknown.
- R3: An AND gate output reads 01 only after every one of its inputs is proven 1.
- R4: An inverter output stays 00 until the sweep after its input is proven.
- R5: Each gate keeps a count of inputs not yet proven. The count is loaded with the fanin on `start`, drops once per input fact, and never goes below zero. An output is resolved from proven facts only, so when no gate has enough facts every gate wire stays 00.
- R6: With `in_i`=0 and `in_j`=1 the result is X=10, Y=01, with `non_constructive`=0.
- R7: With `in_i`=1 and `in_j`=0 the result is X=01, Y=10, with `non_constructive`=0.
- R8: With `in_i`=1 and `in_j`=1 the result is X=00, Y=00, with `non_constructive`=1 while `done` is high.
- R9: With `in_i`=0 and `in_j`=0 the result is X=10, Y=10, with `non_constructive`=0.
- R10: `start` is sampled at one edge, and sweeps run on the following edges. `done` is high right after the edge of the first sweep that changes no wire: after 1 sweep for (1,1), 3 for (0,0) and 5 for (0,1) or (1,0). The number of sweeps never exceeds the number of gate wires plus one.
- R11: A `start` in any state, including during SWEEP, discards the current evaluation and restarts with the newly captured inputs.
- R12: Once a wire is proven it keeps its value until the next `start`, and outputs stay steady while in DONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture inputs and begin a new evaluation |
| in_i | input | 1 | Primary input I |
| in_j | input | 1 | Primary input J |
| x_val | output | 2 | Three-valued state of wire X |
| y_val | output | 2 | Three-valued state of wire Y |
| done | output | 1 | Fixpoint reached |
| non_constructive | output | 1 | Some wire unresolved at the fixpoint (valid with done) |

## Verification
All four input vectors are applied. (0,1) and (1,0) tell apart the two directions of the mutual exclusion. (0,0) shows both AND gates resolving to 0 without any help from the loop. (1,1) is the only vector with no proof, and it separates a true fixpoint check from a guess. Probing the (0,1) run sweep by sweep shows an AND gate resolving early on a 0, and Y waiting for the inverter in front of it. The done latency per vector, a restart during a sweep, and a restart from DONE check the timing and the clearing.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [1:0] {
        T_UNK  = 2'b00,
        T_ONE  = 2'b01,
        T_ZERO = 2'b10
    } tern_t;

    typedef enum logic {
        G_AND = 1'b0,
        G_NOT = 1'b1
    } gkind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SWEEP = 2'd1,
        S_DONE  = 2'd2
    } eval_state_e;

endpackage

// File: rtl/tern_gate.sv
module tern_gate
    import tern_pkg::*;
#(
    parameter gkind_e KIND  = G_AND,
    parameter int     FANIN = 2,
    localparam int    CW    = $clog2(FANIN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  step,
    input  logic [FANIN-1:0][1:0] in_w,
    output logic [1:0]            out_w,
    output logic                  changed
);

    logic [FANIN-1:0] is_zero;
    logic [FANIN-1:0] is_one;
    logic [FANIN-1:0] known;
    logic [FANIN-1:0] seen_q;
    logic [FANIN-1:0] fresh;
    logic [CW-1:0]    pending_q;
    logic [CW-1:0]    fresh_cnt;
    logic [1:0]       eval_w;
    logic [1:0]       out_q;

    for (genvar k = 0; k < FANIN; k++) begin : g_in
        assign is_zero[k] = (in_w[k] == T_ZERO);
        assign is_one[k]  = (in_w[k] == T_ONE);
    end
    assign known = is_zero | is_one;
    assign fresh = known & ~seen_q;

    always_comb begin
        fresh_cnt = '0;
        for (int k = 0; k < FANIN; k++) begin
            fresh_cnt = fresh_cnt + CW'(fresh[k]);
        end
    end

    if (KIND == G_AND) begin : g_and
        always_comb begin
            if (|is_zero)      eval_w = T_ZERO;
            else if (&is_one)  eval_w = T_ONE;
            else               eval_w = T_UNK;
        end
    end else begin : g_not
        always_comb begin
            if (is_zero[0])     eval_w = T_ONE;
            else if (is_one[0]) eval_w = T_ZERO;
            else                eval_w = T_UNK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= T_UNK;
            pending_q <= CW'(FANIN);
            seen_q    <= '0;
        end else if (clear) begin
            out_q     <= T_UNK;
            pending_q <= CW'(FANIN);
            seen_q    <= '0;
        end else if (step) begin
            out_q     <= eval_w;
            pending_q <= pending_q - fresh_cnt;
            seen_q    <= known;
        end
    end

    assign out_w   = out_q;
    assign changed = step && !clear && (eval_w != out_q);

    a_r5_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q <= CW'(FANIN));

    a_r12_proven_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != T_UNK && !clear) |=> out_q == $past(out_q));

    if (KIND == G_AND) begin : g_and_chk
        a_r3_one_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q == T_ONE) |-> pending_q == '0);
    end else begin : g_not_chk
        a_r4_not_waits: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q != T_UNK) |-> (pending_q == '0 && in_w[0] != T_UNK));
    end

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import tern_pkg::*;
#(
    parameter int  NGATES = 4,
    localparam int SCW    = $clog2(NGATES + 2) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic any_change,
    output logic clear,
    output logic step,
    output logic done
);

    eval_state_e    state_q, state_d;
    logic [SCW-1:0] sweep_cnt_q;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = S_SWEEP;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_SWEEP: if (!any_change) state_d = S_DONE;
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        clear = start;
        step  = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_SWEEP: step = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        sweep_cnt_q <= '0;
        else if (start)                    sweep_cnt_q <= '0;
        else if (state_q == S_SWEEP)       sweep_cnt_q <= sweep_cnt_q + 1'b1;
    end

    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SWEEP) |-> sweep_cnt_q <= SCW'(NGATES));

    a_r10_done_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SWEEP && !start && !any_change) |=> done);

    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == S_SWEEP && sweep_cnt_q == '0));

endmodule

// File: rtl/tern_net_eval.sv
module tern_net_eval
    import tern_pkg::*;
#(
    parameter int  NGATES = 4,
    localparam int NWIRES = NGATES + 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_i,
    input  logic       in_j,
    output logic [1:0] x_val,
    output logic [1:0] y_val,
    output logic       done,
    output logic       non_constructive
);

    logic [1:0] w_i, w_j, w_x, w_y, w_nx, w_ny;
    logic       clear, step;
    logic [NGATES-1:0] chg;
    logic [NWIRES-1:0] unk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_i <= T_UNK;
            w_j <= T_UNK;
        end else if (start) begin
            w_i <= in_i ? T_ONE : T_ZERO;
            w_j <= in_j ? T_ONE : T_ZERO;
        end
    end

    tern_gate #(.KIND(G_NOT), .FANIN(1)) u_ny (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .in_w(w_y), .out_w(w_ny), .changed(chg[0]));

    tern_gate #(.KIND(G_AND), .FANIN(2)) u_x (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .in_w({w_i, w_ny}), .out_w(w_x), .changed(chg[1]));

    tern_gate #(.KIND(G_NOT), .FANIN(1)) u_nx (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .in_w(w_x), .out_w(w_nx), .changed(chg[2]));

    tern_gate #(.KIND(G_AND), .FANIN(2)) u_y (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .in_w({w_j, w_nx}), .out_w(w_y), .changed(chg[3]));

    sweep_ctrl #(.NGATES(NGATES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .any_change(|chg),
        .clear(clear), .step(step), .done(done));

    assign unk = {w_i == T_UNK, w_j == T_UNK, w_x == T_UNK,
                  w_y == T_UNK, w_nx == T_UNK, w_ny == T_UNK};

    assign x_val            = w_x;
    assign y_val            = w_y;
    assign non_constructive = done && (|unk);

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (x_val != 2'b11) && (y_val != 2'b11));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (x_val == T_ONE) |-> (y_val == T_ZERO));

    a_r12_done_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(x_val) && $stable(y_val)));

endmodule

// File: tb/tern_net_eval_test.sv
module tern_net_eval_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_i = 1'b0;
    logic       in_j = 1'b0;
    logic [1:0] x_val, y_val;
    logic       done, non_constructive;

    int checks = 0;
    int failures = 0;
    int cyc;

    always #10 clk = ~clk;

    tern_net_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_i(in_i), .in_j(in_j),
        .x_val(x_val), .y_val(y_val), .done(done),
        .non_constructive(non_constructive));

    // {i, j, exp_x[1:0], exp_y[1:0], exp_nc, exp_sweeps[3:0]}
    localparam logic [10:0] VEC [4] = '{
        {1'b0, 1'b1, 2'b10, 2'b01, 1'b0, 4'd5},   // R6
        {1'b1, 1'b0, 2'b01, 2'b10, 1'b0, 4'd5},   // R7
        {1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 4'd1},   // R8
        {1'b0, 1'b0, 2'b10, 2'b10, 1'b0, 4'd3}    // R9
    };
    localparam string VREQ [4] = '{"R6", "R7", "R8", "R9"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic i, input logic j);
        @(negedge clk);
        start = 1'b1; in_i = i; in_j = j;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
    endtask

    task automatic wait_done();
        while (cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (done) break;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check(x_val == 2'b00 && y_val == 2'b00, "R1 reset values", {x_val, y_val}, 0);
        check(!done && !non_constructive, "R1 reset flags", {done, non_constructive}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 4; v++) begin
            pulse_start(VEC[v][10], VEC[v][9]);
            wait_done();
            check(done, {VREQ[v], " done"}, done, 1);
            check(x_val == VEC[v][8:7], {VREQ[v], " x"}, x_val, VEC[v][8:7]);
            check(y_val == VEC[v][6:5], {VREQ[v], " y"}, y_val, VEC[v][6:5]);
            check(non_constructive == VEC[v][4], {VREQ[v], " flag"}, non_constructive, VEC[v][4]);
            check(cyc == VEC[v][3:0], {"R10 sweeps for ", VREQ[v]}, cyc, VEC[v][3:0]);
            if (VEC[v][4]) // R5: no gate had enough facts, nothing resolved
                check(x_val == 2'b00 && y_val == 2'b00, "R5 unproven stays unknown", {x_val, y_val}, 0);
        end

        // R12: outputs steady while in DONE
        repeat (3) @(negedge clk);
        check(done && x_val == 2'b10 && y_val == 2'b10, "R12 steady in done", {done, x_val, y_val}, 5'b11010);

        // Sweep-by-sweep probe of (0,1): R2, R3, R4
        pulse_start(1'b0, 1'b1);
        @(negedge clk); cyc++;
        check(x_val == 2'b10, "R2 early zero", x_val, 2);
        check(y_val == 2'b00, "R4 waits for inverter", y_val, 0);
        @(negedge clk); cyc++;
        check(y_val == 2'b00, "R3 one needs all inputs", y_val, 0);
        @(negedge clk); cyc++;
        check(y_val == 2'b01, "R3 one after all proven", y_val, 1);
        wait_done();
        check(done && cyc == 5, "R10 probe latency", cyc, 5);

        // R11: restart during SWEEP with new inputs
        pulse_start(1'b0, 1'b1);
        @(negedge clk);
        pulse_start(1'b1, 1'b0);
        check(!done && x_val == 2'b00 && y_val == 2'b00, "R11 cleared on restart", {done, x_val, y_val}, 0);
        wait_done();
        check(x_val == 2'b01 && y_val == 2'b10 && cyc == 5, "R11 restart mid sweep", {x_val, y_val, 4'(cyc)}, {2'b01, 2'b10, 4'd5});

        // R11: restart from DONE, non-constructive to constructive
        pulse_start(1'b1, 1'b1);
        wait_done();
        check(non_constructive, "R11 flagged before restart", non_constructive, 1);
        pulse_start(1'b0, 1'b0);
        check(!done && !non_constructive, "R11 flag cleared on restart", {done, non_constructive}, 0);
        wait_done();
        check(x_val == 2'b10 && y_val == 2'b10 && !non_constructive, "R11 restart from done", {x_val, y_val}, 4'b1010);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule